// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side. The first uses a shift register of recent branch outcomes, shared by all branches, to select a 2-bit saturating counter. The second works in two levels. The fetch PC selects a per-branch outcome history, and that history selects a 3-bit saturating counter. A third table of 2-bit counters, indexed by the global history, decides which component the block trusts for each pattern.

A lookup is started by raising `pred_req` with the fetch PC. One clock later the block returns the final direction, both component directions and the global history used for the lookup. When the branch resolves, the pipeline returns the PC, the real outcome and those saved values on the update port. The block then trains the counters. It shifts the outcome into the local history and into the global history. The global history is rebuilt from the returned copy, so an update also acts as a restore.

Top module: `tournament_predictor`

## Requirements
- R1: A synchronous active-high `rst` clears every history to zero. It sets the 2-bit counters to 01 and the 3-bit counters to 011. The first lookup after reset therefore returns history 0, both component directions 0 and a final prediction of not-taken.
- R2: `pred_vld` is high in exactly the cycle after a cycle with `pred_req` high. The prediction outputs returned with it reflect the tables as they stood at that request edge.
- R3: The global history changes only on an update. The new value is `{upd_ghist[GHIST_W-2:0], upd_taken}`, so bit 0 is the most recent outcome and bit i is the outcome i branches earlier (1 = taken).
- R4: The global direction is the MSB of the 2-bit counter at index global history. Each update with that history steps the counter up on taken and down on not-taken. From a strong state, two opposite outcomes are needed to flip the direction.
- R5: The local direction is the MSB of the 3-bit counter indexed by the branch's local history. An update steps the counter selected by the history held before that update.
- R6: The local history entry is selected by PC bits [LHT_IDX_W+1:2]. PCs that differ only outside those bits share an entry. On update the outcome shifts into bit 0 of the entry.
- R7: The chooser counter at index global history is trained only when `upd_gdir` differs from `upd_ldir`. It steps up when the global side was right and down when the local side was right. An MSB of 1 selects the global direction.
- R8: The final prediction equals the chosen component's direction. When both components agree, it equals that common direction.
- R9: Every counter saturates: it holds at all-ones on taken and at zero on not-taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_req | input | 1 | Lookup strobe |
| pred_pc | input | PC_W | Fetch PC for the lookup |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome (1 = taken) |
| upd_ghist | input | GHIST_W | Global history returned from lookup time |
| upd_gdir | input | 1 | Global direction returned from lookup time |
| upd_ldir | input | 1 | Local direction returned from lookup time |
| pred_vld | output | 1 | Lookup result valid |
| pred_taken | output | 1 | Final predicted direction |
| pred_ghist | output | GHIST_W | Global history used for the lookup |
| pred_gdir | output | 1 | Global component direction |
| pred_ldir | output | 1 | Local component direction |

## Verification
The bench targets saturation at both ends of the 2-bit and 3-bit counters. A counter that wraps would turn a strongly taken branch into a not-taken prediction after one more taken outcome. It also targets PCs that alias onto one local-history entry, and the three-way split between training, skipping and direction of the chooser. A chooser that trained on agreement would drift toward one side and cost accuracy on patterns that only the other side follows. Bit order and restore of the global history are checked as well. A reversed shift or a shift without an update would point every later lookup at the wrong counters, and a bench that models the tables arithmetically sees that at once in the returned history and directions.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic {
        SRC_LOCAL  = 1'b0,
        SRC_GLOBAL = 1'b1
    } src_e;

    // saturating step of a counter of width w (w <= 8)
    function automatic logic [7:0] sat_step(input logic [7:0] v, input int unsigned w, input logic up);
        logic [7:0] top_v;
        top_v = 8'((1 << w) - 1);
        if (up)
            return (v == top_v) ? v : v + 8'd1;
        else
            return (v == 8'd0) ? v : v - 8'd1;
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table import tp_pkg::*; #(
    parameter int IDX_W = 12,
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_msb,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W - 1)) - 1);

    logic [CTR_W-1:0] mem [DEPTH];
    logic [7:0]       nxt;

    assign rd_msb = mem[rd_idx][CTR_W-1];

    always_comb begin
        nxt = sat_step(8'(mem[wr_idx]), CTR_W, wr_up);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= WEAK_NT;
        end else if (wr_en) begin
            mem[wr_idx] <= nxt[CTR_W-1:0];
        end
    end

    logic unused_nxt_hi;
    assign unused_nxt_hi = ^nxt;

endmodule

// File: rtl/tp_local_hist.sv
module tp_local_hist #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_taken,
    output logic [HIST_W-1:0] wr_old_hist
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] mem [DEPTH];
    logic [HIST_W-1:0] wr_new_hist;

    assign rd_hist     = mem[rd_idx];
    assign wr_old_hist = mem[wr_idx];

    generate
        if (HIST_W > 1) begin : g_shift
            assign wr_new_hist = {wr_old_hist[HIST_W-2:0], wr_taken};
        end else begin : g_single
            assign wr_new_hist = wr_taken;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_new_hist;
        end
    end

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor import tp_pkg::*; #(
    parameter int PC_W      = 32,
    parameter int ALIGN_W   = 2,
    parameter int GHIST_W   = 12,
    parameter int LHT_IDX_W = 10,
    parameter int LHIST_W   = 10,
    parameter int GCTR_W    = 2,
    parameter int LCTR_W    = 3,
    parameter int CHS_W     = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pred_req,
    input  logic [PC_W-1:0]    pred_pc,
    input  logic               upd_valid,
    input  logic [PC_W-1:0]    upd_pc,
    input  logic               upd_taken,
    input  logic [GHIST_W-1:0] upd_ghist,
    input  logic               upd_gdir,
    input  logic               upd_ldir,
    output logic               pred_vld,
    output logic               pred_taken,
    output logic [GHIST_W-1:0] pred_ghist,
    output logic               pred_gdir,
    output logic               pred_ldir
);
    localparam int LPC_HI = ALIGN_W + LHT_IDX_W;

    logic [GHIST_W-1:0]   ghist_q, ghist_nx;
    logic [LHT_IDX_W-1:0] p_lidx, u_lidx;
    logic [LHIST_W-1:0]   p_lhist, u_lhist;
    logic                 p_gdir, p_ldir, p_pick, p_dir;
    logic                 chs_train, chs_up;
    src_e                 p_src;

    assign p_lidx = pred_pc[LPC_HI-1:ALIGN_W];
    assign u_lidx = upd_pc[LPC_HI-1:ALIGN_W];

    // first level of the local side: per-branch outcome history
    tp_local_hist #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
        .clk(clk), .rst(rst),
        .rd_idx(p_lidx), .rd_hist(p_lhist),
        .wr_en(upd_valid), .wr_idx(u_lidx), .wr_taken(upd_taken),
        .wr_old_hist(u_lhist)
    );

    // second level of the local side: counters indexed by local history
    tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_ltab (
        .clk(clk), .rst(rst),
        .rd_idx(p_lhist), .rd_msb(p_ldir),
        .wr_en(upd_valid), .wr_idx(u_lhist), .wr_up(upd_taken)
    );

    // global side: counters indexed by global history
    tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_gtab (
        .clk(clk), .rst(rst),
        .rd_idx(ghist_q), .rd_msb(p_gdir),
        .wr_en(upd_valid), .wr_idx(upd_ghist), .wr_up(upd_taken)
    );

    // selector: trained only on disagreement, toward the correct side
    assign chs_train = upd_valid && (upd_gdir != upd_ldir);
    assign chs_up    = (upd_gdir == upd_taken);

    tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CHS_W)) u_chs (
        .clk(clk), .rst(rst),
        .rd_idx(ghist_q), .rd_msb(p_pick),
        .wr_en(chs_train), .wr_idx(upd_ghist), .wr_up(chs_up)
    );

    assign p_src = p_pick ? SRC_GLOBAL : SRC_LOCAL;
    assign p_dir = (p_src == SRC_GLOBAL) ? p_gdir : p_ldir;

    generate
        if (GHIST_W > 1) begin : g_gshift
            assign ghist_nx = {upd_ghist[GHIST_W-2:0], upd_taken};
        end else begin : g_gsingle
            assign ghist_nx = upd_taken;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ghist_q    <= '0;
            pred_vld   <= 1'b0;
            pred_taken <= 1'b0;
            pred_ghist <= '0;
            pred_gdir  <= 1'b0;
            pred_ldir  <= 1'b0;
        end else begin
            if (upd_valid) ghist_q <= ghist_nx;
            pred_vld <= pred_req;
            if (pred_req) begin
                pred_taken <= p_dir;
                pred_ghist <= ghist_q;
                pred_gdir  <= p_gdir;
                pred_ldir  <= p_ldir;
            end
        end
    end

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pred_pc[PC_W-1:LPC_HI], pred_pc[ALIGN_W-1:0],
                              upd_pc[PC_W-1:LPC_HI], upd_pc[ALIGN_W-1:0]};

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int GHIST_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               pred_req,
    input logic               upd_valid,
    input logic               pred_vld,
    input logic               pred_taken,
    input logic               pred_gdir,
    input logic               pred_ldir,
    input logic [GHIST_W-1:0] ghist_q
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!pred_vld && ghist_q == '0));

    assert_vld_follows_R2: assert property (@(posedge clk) disable iff (rst)
        pred_req |=> pred_vld);

    assert_vld_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !pred_req |=> !pred_vld);

    assert_hist_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(ghist_q));

    assert_agree_pick_R8: assert property (@(posedge clk) disable iff (rst)
        (pred_vld && pred_gdir == pred_ldir) |-> pred_taken == pred_gdir);

endmodule

bind tournament_predictor tp_checker #(.GHIST_W(GHIST_W)) u_chk (
    .clk(clk), .rst(rst), .pred_req(pred_req), .upd_valid(upd_valid),
    .pred_vld(pred_vld), .pred_taken(pred_taken), .pred_gdir(pred_gdir),
    .pred_ldir(pred_ldir), .ghist_q(ghist_q)
);

// File: tb/sim_tournament_predictor.sv
module sim_tournament_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int GW = 4;
    localparam int LI = 3;
    localparam int LH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pred_req = 1'b0;
    logic [31:0]   pred_pc = '0;
    logic          upd_valid = 1'b0;
    logic [31:0]   upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [GW-1:0] upd_ghist = '0;
    logic          upd_gdir = 1'b0;
    logic          upd_ldir = 1'b0;
    logic          pred_vld, pred_taken, pred_gdir, pred_ldir;
    logic [GW-1:0] pred_ghist;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [1:0]    m_gt  [1 << GW];
    logic [1:0]    m_ch  [1 << GW];
    logic [2:0]    m_lc  [1 << LH];
    logic [LH-1:0] m_lht [1 << LI];
    logic [GW-1:0] m_gh;

    always #(CLK_PERIOD/2) clk = ~clk;

    tournament_predictor #(.GHIST_W(GW), .LHT_IDX_W(LI), .LHIST_W(LH)) u0 (
        .clk(clk), .rst(rst), .pred_req(pred_req), .pred_pc(pred_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_ghist(upd_ghist), .upd_gdir(upd_gdir), .upd_ldir(upd_ldir),
        .pred_vld(pred_vld), .pred_taken(pred_taken), .pred_ghist(pred_ghist),
        .pred_gdir(pred_gdir), .pred_ldir(pred_ldir)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < (1 << GW); i++) begin m_gt[i] = 2'b01; m_ch[i] = 2'b01; end
        for (int i = 0; i < (1 << LH); i++) m_lc[i] = 3'b011;
        for (int i = 0; i < (1 << LI); i++) m_lht[i] = '0;
        m_gh = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    function automatic int pidx(input logic [31:0] pc);
        return int'(pc[LI+1:2]);
    endfunction

    // one lookup, compared with the reference, then the resolving update
    task automatic do_branch(input logic [31:0] pc, input logic t);
        logic eg, el, ep;
        logic [2:0] lv;
        logic [LH-1:0] lh;
        int pi;
        pi = pidx(pc);
        eg = m_gt[m_gh][1];
        el = m_lc[m_lht[pi]][2];
        ep = m_ch[m_gh][1] ? eg : el;
        @(negedge clk);
        pred_req = 1'b1;
        pred_pc  = pc;
        @(negedge clk);
        pred_req = 1'b0;
        chk("R2 valid after request", 32'(pred_vld), 32'd1);
        chk("R3 global history", 32'(pred_ghist), 32'(m_gh));
        chk("R4 R9 global direction", 32'(pred_gdir), 32'(eg));
        chk("R5 R6 local direction", 32'(pred_ldir), 32'(el));
        chk("R7 R8 final prediction", 32'(pred_taken), 32'(ep));
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = t;
        upd_ghist = m_gh;
        upd_gdir  = eg;
        upd_ldir  = el;
        @(negedge clk);
        upd_valid = 1'b0;
        chk("R2 valid drops", 32'(pred_vld), 32'd0);
        // reference training
        if (t) begin if (m_gt[m_gh] != 2'b11) m_gt[m_gh] = m_gt[m_gh] + 2'd1; end
        else   begin if (m_gt[m_gh] != 2'b00) m_gt[m_gh] = m_gt[m_gh] - 2'd1; end
        lh = m_lht[pi];
        lv = m_lc[lh];
        if (t) begin if (lv != 3'b111) lv = lv + 3'd1; end
        else   begin if (lv != 3'b000) lv = lv - 3'd1; end
        m_lc[lh] = lv;
        m_lht[pi] = {lh[LH-2:0], t};
        if (eg != el) begin
            if (eg == t) begin if (m_ch[m_gh] != 2'b11) m_ch[m_gh] = m_ch[m_gh] + 2'd1; end
            else         begin if (m_ch[m_gh] != 2'b00) m_ch[m_gh] = m_ch[m_gh] - 2'd1; end
        end
        m_gh = {m_gh[GW-2:0], t};
    endtask

    task automatic check_reset_state();
        @(negedge clk);
        pred_req = 1'b1;
        pred_pc  = 32'h0000_1234;
        @(negedge clk);
        pred_req = 1'b0;
        chk("R1 history after reset", 32'(pred_ghist), 32'd0);
        chk("R1 global dir after reset", 32'(pred_gdir), 32'd0);
        chk("R1 local dir after reset", 32'(pred_ldir), 32'd0);
        chk("R1 prediction after reset", 32'(pred_taken), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        check_reset_state();

        // R3: lookups without updates leave the history alone
        begin
            logic [GW-1:0] h0;
            do_branch(32'h100, 1'b1);
            do_branch(32'h100, 1'b0);
            h0 = m_gh;
            repeat (3) begin
                @(negedge clk); pred_req = 1'b1; pred_pc = 32'h200;
                @(negedge clk); pred_req = 1'b0;
                chk("R3 history held without update", 32'(pred_ghist), 32'(h0));
            end
            chk("R3 bit order newest at bit0", 32'(h0[1:0]), 32'b10);
        end

        // R4 R9: always taken, then always not taken; saturation both ends
        for (int i = 0; i < 12; i++) do_branch(32'h40, 1'b1);
        for (int i = 0; i < 12; i++) do_branch(32'h40, 1'b0);

        // R5: alternating pattern on one PC
        for (int i = 0; i < 24; i++) do_branch(32'h84, i[0]);

        // loop pattern T T T N
        for (int i = 0; i < 40; i++) do_branch(32'h48, (i % 4) != 3);

        // R6: aliasing PCs that share a local history entry
        for (int i = 0; i < 20; i++) begin
            do_branch(32'h0C, 1'b1);
            do_branch(32'h0C + (32'd1 << (LI + 2)), 1'b0);
        end

        // R7: mixed branches so components disagree often
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] pc;
            logic t;
            pc = {24'h0, 4'($urandom_range(0, 15)), 2'b00} + 32'h400;
            case (pc[4:2] % 3)
                0: t = 1'b1;
                1: t = m_gh[0];
                default: t = 1'($urandom_range(0, 1));
            endcase
            do_branch(pc, t);
        end

        // R1: reset during operation restores the initial state
        do_reset();
        check_reset_state();
        for (int i = 0; i < 30; i++) do_branch(32'h60 + 32'(4 * (i % 5)), (i % 3) == 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule